// File: doc/BRIEF.md
# OTG ID Pin Classifier

This block sits behind the analog comparators on the ID pin and reduces their four threshold outputs to one debounced ID class: floating, A-device accessory, B-device accessory that cannot connect, B-device accessory that can connect, or grounded. The comparators form a thermometer code in which each bit reports that the pin resistance lies below one threshold. Only a monotonic code is accepted. A new class must hold steady for a number of slow ticks before it is adopted. The slow tick is a one-clock enable that arrives at about 32 kHz.

Detection runs only while the ID pull-up is enabled. Turning on the pull-up, or turning on its weak variant while the pull-up is on, opens a mask window. During that window the outputs report grounded, so the link sees a settled pin before it sees a classification. The block produces a 3-bit class code, the single ID bit passed to the link, and a one-clock pulse each time the adopted class changes.

Top module: `id_pin_classifier`

## Requirements
- R1: The comparator input `cmp_below[3:0]` is a thermometer code. Bit 0 means below the floating/A threshold, bit 1 below the A/B threshold, bit 2 below the B/C threshold and bit 3 below the C/ground threshold. The patterns 0000, 0001, 0011, 0111 and 1111 select the class codes 4 (floating), 3 (A), 2 (B), 1 (C) and 0 (grounded).
- R2: Any other comparator pattern is ignored. The adopted class is held and the stability count is cleared.
- R3: A move to grounded or to floating is adopted on the SHORT_TICKS-th slow tick after the new pattern has settled, and not before.
- R4: A move to class A, B or C is adopted on the LONG_TICKS-th slow tick after the new pattern has settled, and not before.
- R5: Any change to a different valid pattern before adoption restarts the count from zero.
- R6: `id_bit` is 0 for the grounded class and for class A. It is 1 for classes B, C and floating.
- R7: A rising edge of `pullup_en`, or a rising edge of `weak_pullup_en` while `pullup_en` is high, opens a mask for MASK_TICKS slow ticks. While the mask is open, `id_class` reads 0 and `id_bit` reads 0. Detection keeps running underneath.
- R8: `id_change_irq` is high for exactly one clock, in the same cycle that the new adopted class first appears. It stays low for any adoption made while the mask is open.
- R9: While `pullup_en` is low, the class is forced to grounded, no detection takes place and no pulse is issued.
- R10: After a synchronous reset (`rst_n` low), `id_class` is 0, `id_bit` is 0 and `id_change_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-clock enable at the slow (about 32 kHz) rate |
| pullup_en | input | 1 | ID pull-up enable; detection runs only while it is high |
| weak_pullup_en | input | 1 | Selects the weak pull-up; a rise of this signal reopens the mask |
| cmp_below | input | 4 | Threshold comparator outputs, thermometer coded |
| id_class | output | 3 | Reported ID class code |
| id_bit | output | 1 | ID bit reported to the link |
| id_change_irq | output | 1 | One-clock pulse when the adopted class changes |

## Verification
Wrong stability-count state shows at the ports as a class adopted one or more ticks early or late. The bench checks the class after every single tick of each transition, so such an error appears within one tick. A wrong candidate register shows as a missing restart (R5) or as a broken pattern being adopted (R2). A stuck mask state shows as `id_class` staying 0 after the window should have closed, or as a pulse leaking out during the window. Both are visible on the tick where the window ends. The bench sweeps every ordered pair of the five classes, so each decode value and both debounce lengths are seen at the outputs.

// File: rtl/id_cls_pkg.sv
// Shared types for the ID pin classifier.
// Assumes: class codes are ordered by decreasing pull-down resistance
// from floating (4) down to grounded (0).
package id_cls_pkg;

    typedef enum logic [2:0] {
        CLS_GND = 3'd0,
        CLS_C   = 3'd1,
        CLS_B   = 3'd2,
        CLS_A   = 3'd3,
        CLS_FLT = 3'd4
    } id_class_e;

    // Returns 1 when the class falls under the short debounce length.
    function automatic logic is_short_class(input id_class_e c);
        return (c == CLS_GND) || (c == CLS_FLT);
    endfunction

endpackage

// File: rtl/id_cmp_decode.sv
// Converts the comparator thermometer code into a class code.
// Assumes: bit i set means the pin resistance is below threshold i, so
// a legal pattern never has a higher bit set above a clear lower bit.
module id_cmp_decode
    import id_cls_pkg::*;
#(
    parameter int NUM_THR = 4
) (
    input  logic [NUM_THR-1:0] cmp_below,
    output id_class_e          dec_class,
    output logic               dec_valid
);
    localparam int CW = $clog2(NUM_THR + 1);

    logic [NUM_THR-2:0] pair_ok;
    logic [CW-1:0]      ones;

    // Each adjacent pair must respect the thermometer order.
    for (genvar i = 0; i < NUM_THR - 1; i++) begin : g_pair
        assign pair_ok[i] = cmp_below[i] | ~cmp_below[i+1];
    end

    // Count set thresholds; the count directly gives the class distance.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            ones = ones + CW'(cmp_below[i]);
        end
    end

    // Map the number of crossed thresholds onto the class code.
    always_comb begin
        dec_valid = &pair_ok;
        if (ones == '0) begin
            dec_class = CLS_FLT;
        end else begin
            dec_class = id_class_e'(3'(NUM_THR) - 3'(ones));
        end
    end

endmodule

// File: rtl/id_debounce.sv
// Debounces the decoded class: a candidate must stay stable for a
// class-dependent number of slow ticks before it becomes the adopted class.
// Assumes: SHORT_TICKS and LONG_TICKS are at least 2; detection runs only
// while det_en is high, otherwise the class returns to grounded.
module id_debounce
    import id_cls_pkg::*;
#(
    parameter int SHORT_TICKS = 56,
    parameter int LONG_TICKS  = 1520
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      det_en,
    input  id_class_e dec_class,
    input  logic      dec_valid,
    output id_class_e cls,
    output logic      chg
);
    localparam int MAXT = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    id_class_e     cand;
    logic [CW-1:0] cnt;
    logic [CW-1:0] need_m1;

    // Select the debounce length for the class being tracked.
    always_comb begin
        need_m1 = is_short_class(cand) ? CW'(SHORT_TICKS - 1) : CW'(LONG_TICKS - 1);
    end

    // Track the candidate, count stable ticks and adopt on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_en) begin
            cand <= CLS_GND;
            cls  <= CLS_GND;
            cnt  <= '0;
            chg  <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (!dec_valid) begin
                cnt <= '0;
            end else if (dec_class != cand) begin
                cand <= dec_class;
                cnt  <= '0;
            end else if (cand == cls) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == need_m1) begin
                    cls <= cand;
                    chg <= 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: a broken comparator pattern never moves the adopted class.
    a_r2_invalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && !dec_valid) |=> $stable(cls));

    // R9: with the pull-up off the class is grounded one clock later.
    a_r9_off_is_ground: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (cls == CLS_GND));

    // R3/R4: adoption only ever happens on a slow tick.
    a_r3_adopt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && $past(det_en) && (cls != $past(cls))) |-> $past(tick));

endmodule

// File: rtl/id_mask.sv
// Mask window: opens when the pull-up turns on or the weak pull-up is
// selected, stays open for MASK_TICKS slow ticks.
// Assumes: the window is meaningless while the pull-up is off and is cleared.
module id_mask #(
    parameter int MASK_TICKS = 1136
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pullup_en,
    input  logic weak_pullup_en,
    output logic active
);
    localparam int CW = $clog2(MASK_TICKS + 1);

    logic          pu_q;
    logic          wk_q;
    logic [CW-1:0] cnt;
    logic          start;

    // A window starts on an enable edge while the pull-up is on.
    assign start = pullup_en & (~pu_q | (weak_pullup_en & ~wk_q));

    // Remember the enables of the previous clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q <= 1'b0;
            wk_q <= 1'b0;
        end else begin
            pu_q <= pullup_en;
            wk_q <= weak_pullup_en;
        end
    end

    // Open, count down and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !pullup_en) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == CW'(MASK_TICKS - 1)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7: turning on the pull-up always opens the window.
    a_r7_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en && !pu_q) |=> active);

    // R7: the window never survives the pull-up being switched off.
    a_r7_off_closes: assert property (@(posedge clk) disable iff (!rst_n)
        !pullup_en |=> !active);

endmodule

// File: rtl/id_pin_classifier.sv
// Top of the ID pin classifier: decode, debounce, mask and report.
// Assumes: slow_tick is a single-clock enable; cmp_below is already
// synchronous to clk.
module id_pin_classifier
    import id_cls_pkg::*;
#(
    parameter int NUM_THR     = 4,
    parameter int SHORT_TICKS = 56,
    parameter int LONG_TICKS  = 1520,
    parameter int MASK_TICKS  = 1136
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               pullup_en,
    input  logic               weak_pullup_en,
    input  logic [NUM_THR-1:0] cmp_below,
    output logic [2:0]         id_class,
    output logic               id_bit,
    output logic               id_change_irq
);
    id_class_e dec_class;
    logic      dec_valid;
    id_class_e cls;
    logic      chg;
    logic      masked;

    id_cmp_decode #(.NUM_THR(NUM_THR)) u_dec (
        .cmp_below (cmp_below),
        .dec_class (dec_class),
        .dec_valid (dec_valid)
    );

    id_debounce #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (slow_tick),
        .det_en    (pullup_en),
        .dec_class (dec_class),
        .dec_valid (dec_valid),
        .cls       (cls),
        .chg       (chg)
    );

    id_mask #(.MASK_TICKS(MASK_TICKS)) u_mask (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (slow_tick),
        .pullup_en      (pullup_en),
        .weak_pullup_en (weak_pullup_en),
        .active         (masked)
    );

    // Report grounded while masked, otherwise the adopted class.
    always_comb begin
        id_class      = masked ? 3'(CLS_GND) : 3'(cls);
        id_bit        = !masked && (cls != CLS_GND) && (cls != CLS_A);
        id_change_irq = chg && !masked;
    end

    // R8: the change pulse lasts one clock.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        id_change_irq |=> !id_change_irq);

    // R9: no pulse while the pull-up is off.
    a_r9_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pullup_en |=> !id_change_irq);

endmodule

// File: tb/sim_id_pin_classifier.sv
module sim_id_pin_classifier;
    localparam int SH = 3;
    localparam int LG = 5;
    localparam int MK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pu = 1'b0;
    logic       wk = 1'b0;
    logic [3:0] cmp = 4'b0000;
    logic [2:0] id_class;
    logic       id_bit;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    id_pin_classifier #(.NUM_THR(4), .SHORT_TICKS(SH), .LONG_TICKS(LG),
                        .MASK_TICKS(MK)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(tick), .pullup_en(pu),
        .weak_pullup_en(wk), .cmp_below(cmp), .id_class(id_class),
        .id_bit(id_bit), .id_change_irq(irq)
    );

    // Pattern with k thresholds crossed; class code per R1.
    function automatic logic [3:0] pat(input int k);
        return 4'((1 << k) - 1);
    endfunction
    function automatic logic [2:0] code(input int k);
        return (k == 0) ? 3'd4 : 3'(4 - k);
    endfunction
    function automatic int need(input int k);
        return (k == 0 || k == 4) ? SH : LG;
    endfunction
    function automatic logic idx(input logic [2:0] c);
        return !(c == 3'd0 || c == 3'd3);
    endfunction

    task automatic chk(input string req, input logic [2:0] c_exp,
                       input logic id_exp, input logic irq_exp);
        checks++;
        if (id_class !== c_exp || id_bit !== id_exp || irq !== irq_exp) begin
            fails++;
            $display("FAIL %s: class=%0d id=%0b irq=%0b expected class=%0d id=%0b irq=%0b",
                     req, id_class, id_bit, irq, c_exp, id_exp, irq_exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic apply(input logic [3:0] p);
        @(negedge clk) cmp = p;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset", 3'd0, 1'b0, 1'b0);

        // R9: pull-up off, floating pattern, ticks do nothing.
        cmp = pat(0);
        for (int i = 0; i < 6; i++) begin
            do_tick();
            chk("R9 pull-up off", 3'd0, 1'b0, 1'b0);
        end

        // R7: pull-up on opens the mask; floating adopted underneath.
        @(negedge clk) pu = 1'b1;
        @(negedge clk);
        for (int i = 1; i <= MK; i++) begin
            do_tick();
            if (i < MK) chk("R7 mask open", 3'd0, 1'b0, 1'b0);
            else        chk("R7 mask closed", 3'd4, 1'b1, 1'b0);
        end

        // R7: weak pull-up rise reopens the mask.
        @(negedge clk) wk = 1'b1;
        @(negedge clk);
        chk("R7 weak reopen", 3'd0, 1'b0, 1'b0);
        for (int i = 1; i <= MK; i++) begin
            do_tick();
            if (i < MK) chk("R7 weak mask", 3'd0, 1'b0, 1'b0);
            else        chk("R7 weak mask end", 3'd4, 1'b1, 1'b0);
        end

        // R1 R3 R4 R6 R8: every ordered pair of classes.
        for (int f = 0; f <= 4; f++) begin
            for (int t = 0; t <= 4; t++) begin
                apply(pat(f));
                for (int i = 0; i < need(f); i++) do_tick();
                apply(pat(t));
                if (t == f) begin
                    for (int i = 0; i < LG; i++) begin
                        do_tick();
                        chk("R8 no change", code(f), idx(code(f)), 1'b0);
                    end
                end else begin
                    for (int i = 1; i < need(t); i++) begin
                        do_tick();
                        chk(need(t) == SH ? "R3 early" : "R4 early",
                            code(f), idx(code(f)), 1'b0);
                    end
                    do_tick();
                    chk(need(t) == SH ? "R3 R1 R6 R8 adopt" : "R4 R1 R6 R8 adopt",
                        code(t), idx(code(t)), 1'b1);
                    @(negedge clk);
                    chk("R8 pulse ends", code(t), idx(code(t)), 1'b0);
                end
            end
        end

        // R2: invalid pattern from floating holds class.
        apply(pat(0));
        for (int i = 0; i < SH; i++) do_tick();
        apply(4'b0101);
        for (int i = 0; i < LG + 2; i++) begin
            do_tick();
            chk("R2 invalid held", 3'd4, 1'b1, 1'b0);
        end

        // R5: B for part of the count, then C restarts the count.
        apply(pat(2));
        for (int i = 0; i < LG - 2; i++) do_tick();
        apply(pat(3));
        for (int i = 1; i < LG; i++) begin
            do_tick();
            chk("R5 restart", 3'd4, 1'b1, 1'b0);
        end
        do_tick();
        chk("R5 adopt C", 3'd1, 1'b1, 1'b1);

        // R2: invalid glitch mid-count clears the count.
        apply(pat(2));
        for (int i = 0; i < LG - 2; i++) do_tick();
        apply(4'b1010);
        apply(pat(2));
        for (int i = 1; i < LG; i++) begin
            do_tick();
            chk("R2 count cleared", 3'd1, 1'b1, 1'b0);
        end
        do_tick();
        chk("R2 adopt B", 3'd2, 1'b1, 1'b1);

        // R9: pull-up off forces ground without a pulse.
        @(negedge clk) pu = 1'b0;
        @(negedge clk);
        chk("R9 forced ground", 3'd0, 1'b0, 1'b0);
        do_tick();
        chk("R9 stays ground", 3'd0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule